// File: doc/BRIEF.md
# Windowed Watchdog Timer Controller

This block supervises software by counting pulses of a slow 1 kHz tick. Once enabled, software must periodically issue a kick (a watchdog restart). If the tick count reaches the configured timeout before a kick arrives, the block raises a one-cycle system-reset request and starts counting again. In window mode, the timeout is split into two parts. First comes a closed interval, in which a kick counts as a fault. It is followed by an open interval, in which a kick is legal. A kick during the closed interval raises the reset request and also an early-kick flag.

Two 8-bit configuration registers sit behind a plain write/read port. The control register holds the timeout code and the enable. The window register holds the closed-interval code and the window enable. A write takes effect only when three things hold: bit 0 (change-enable) of the written byte is one, a protection interval opened by a dedicated unlock strobe is still running, and the written code is legal. A lock input freezes both period fields, while the enable bits stay writable. After reset, both period fields hold values from fuse inputs.

Top module: `winwdog_top`

## Requirements
- R1: After reset the control period reads the `fuse_per` code, the window period reads the `fuse_wper` code, both enables read 0, and `sys_rst_req` and `rst_early` are low.
- R2: `rd_sel` = 0 reads the control register and 1 reads the window register. In both, bits 5:2 are the period code and bit 1 is the enable. Bit 0 (change-enable) and bits 7:6 always read 0, whatever was written there.
- R3: A write whose bit 0 is 0 changes no register field.
- R4: An `unlock_stb` sampled at one clock edge lets writes through on exactly the next 4 edges. A write sampled on any other edge is discarded. `wr_sel` = 0 targets the control register and 1 targets the window register.
- R5: With `per_lock` low, a write carrying a period code of 11 to 15 is rejected as a whole, and the register keeps its previous contents.
- R6: With `per_lock` high, an otherwise valid write updates the enable bit and leaves the period code unchanged. The written code is not checked in this case.
- R7: Period code c (0 to 10) stands for 8·2^c ticks, so 6 = 512, 7 = 1024, 8 = 2048, 9 = 4096 and 10 = 8192 ticks.
- R8: In normal mode with the block enabled and no kick, the N-th tick since the last restart (N from the control code) raises `sys_rst_req` for one cycle, one clock after the edge that samples that tick. `rst_early` stays low, and counting restarts from zero.
- R9: A kick in normal mode, or during the open interval of window mode, restarts the count without any request.
- R10: In window mode, a kick while fewer than W ticks (W from the window code) have elapsed since the restart raises `sys_rst_req` and `rst_early` together for one cycle and restarts the count.
- R11: In window mode, the timeout falls on tick W+N after the restart.
- R12: With window mode off, the window period code has no effect on timeout or on kicks.
- R13: While the enable is 0, the count is held at zero and no request is raised. Every accepted write also restarts the count.
- R14: A kick and a tick sampled on the same edge act as a kick alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle strobe per 1 kHz period |
| kick | input | 1 | Software watchdog restart |
| unlock_stb | input | 1 | Opens the protected-write interval |
| per_lock | input | 1 | Freezes both period fields |
| fuse_per | input | 4 | Power-on control period code |
| fuse_wper | input | 4 | Power-on window period code |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control, 1 window |
| wr_data | input | 8 | Write byte |
| rd_sel | input | 1 | Read target: 0 control, 1 window |
| rd_data | output | 8 | Read byte (combinational) |
| sys_rst_req | output | 1 | One-cycle system-reset request |
| rst_early | output | 1 | Marks a request caused by an early kick |

## Verification
Register fields change on the edge that samples the write, and `rd_data` follows with no further delay. Readback checks therefore sample a few nanoseconds after the next falling edge. The request and the early flag are registered once, so they appear in the cycle after the edge that samples the deciding tick or kick. A behavioural model advances on that same edge, and every cycle its values are compared 5 ns after the rising edge, while inputs change only on falling edges. The directed timeout checks apply N-1 ticks, confirm that no pulse has appeared, then apply one more tick and expect exactly one pulse. The unlock checks place writes on the fourth and fifth edges after the strobe.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;

   localparam int unsigned REG_W    = 8;
   localparam int unsigned CODE_W   = 4;
   localparam int unsigned CE_BIT   = 0;
   localparam int unsigned EN_BIT   = 1;
   localparam int unsigned CODE_LSB = 2;
   localparam int unsigned NUM_REGS = 2;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_WIN  = 1'b1
   } reg_sel_e;

   typedef struct packed {
      logic [CODE_W-1:0] code;
      logic              en;
   } cfg_t;

endpackage

// File: rtl/winwdog_unlock.sv
module winwdog_unlock #(
   parameter int unsigned OPEN_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   output logic open_o
);
   localparam int unsigned CW = $clog2(OPEN_CYC + 1);

   if (OPEN_CYC < 1) begin : g_bad_open
      $error("OPEN_CYC must be at least 1");
   end

   logic [CW-1:0] left_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (strobe) begin
         left_q <= CW'(OPEN_CYC);
      end else if (left_q != '0) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign open_o = (left_q != '0);

endmodule

// File: rtl/winwdog_tickin.sv
module winwdog_tickin #(
   parameter bit LEVEL_TICK = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick_in,
   output logic tick_o
);
   if (LEVEL_TICK) begin : g_level
      logic [2:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sync_q <= '0;
         end else begin
            sync_q <= {sync_q[1:0], tick_in};
         end
      end
      assign tick_o = sync_q[1] & ~sync_q[2];
   end else begin : g_strobe
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign tick_o = tick_in;
   end

endmodule

// File: rtl/winwdog_cfgreg.sv
module winwdog_cfgreg
   import winwdog_pkg::*;
#(
   parameter int unsigned MAX_CODE = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] fuse_code,
   input  logic              wr_hit,
   input  logic              wr_ce,
   input  logic              wr_en_bit,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              unlocked,
   input  logic              per_lock,
   output cfg_t              cfg_o,
   output logic              accepted_o
);
   if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_code
      $error("MAX_CODE does not fit in the code field");
   end

   logic code_ok;

   assign code_ok    = per_lock || (wr_code <= CODE_W'(MAX_CODE));
   assign accepted_o = wr_hit && unlocked && wr_ce && code_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_o.code <= fuse_code;
         cfg_o.en   <= 1'b0;
      end else if (accepted_o) begin
         cfg_o.en <= wr_en_bit;
         if (!per_lock) begin
            cfg_o.code <= wr_code;
         end
      end
   end

endmodule

// File: rtl/winwdog_count.sv
module winwdog_count
   import winwdog_pkg::*;
#(
   parameter int unsigned BASE_SHIFT = 3,
   parameter int unsigned MAX_CODE   = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              kick,
   input  logic              restart,
   input  logic              run,
   input  logic              win_mode,
   input  logic [CODE_W-1:0] per_code,
   input  logic [CODE_W-1:0] win_code,
   output logic              req_o,
   output logic              early_o
);
   localparam int unsigned CNT_W = BASE_SHIFT + MAX_CODE + 2;

   if (CNT_W > 31) begin : g_bad_width
      $error("count width too large");
   end

   function automatic logic [CNT_W-1:0] span_of(input logic [CODE_W-1:0] c);
      logic [CODE_W-1:0] cc;
      cc = (c > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : c;
      return CNT_W'(1) << (BASE_SHIFT + 32'(cc));
   endfunction

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_span;
   logic [CNT_W-1:0] win_span;
   logic [CNT_W-1:0] limit;
   logic             closed;
   logic             expire;

   always_comb begin
      per_span = span_of(per_code);
      win_span = span_of(win_code);
      limit    = per_span + (win_mode ? win_span : '0);
      closed   = win_mode && (cnt_q < win_span);
      expire   = tick && (cnt_q == (limit - 1'b1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         req_o   <= 1'b0;
         early_o <= 1'b0;
      end else begin
         req_o   <= 1'b0;
         early_o <= 1'b0;
         if (!run || restart) begin
            cnt_q <= '0;
         end else if (kick) begin
            cnt_q <= '0;
            if (closed) begin
               req_o   <= 1'b1;
               early_o <= 1'b1;
            end
         end else if (expire) begin
            cnt_q <= '0;
            req_o <= 1'b1;
         end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/winwdog_top.sv
module winwdog_top
   import winwdog_pkg::*;
#(
   parameter int unsigned BASE_SHIFT = 3,
   parameter int unsigned MAX_CODE   = 10,
   parameter int unsigned OPEN_CYC   = 4,
   parameter bit          LEVEL_TICK = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       kick,
   input  logic       unlock_stb,
   input  logic       per_lock,
   input  logic [3:0] fuse_per,
   input  logic [3:0] fuse_wper,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   input  logic       rd_sel,
   output logic [7:0] rd_data,
   output logic       sys_rst_req,
   output logic       rst_early
);
   localparam int unsigned PAD_W = REG_W - CODE_W - CODE_LSB;

   if (CODE_LSB + CODE_W > REG_W) begin : g_bad_layout
      $error("register layout overflows REG_W");
   end

   logic              unlocked;
   logic              tick_int;
   logic              restart;
   logic              unused_rsvd;
   logic [CODE_W-1:0] fuse_arr [NUM_REGS];
   cfg_t              cfg_arr  [NUM_REGS];
   logic [NUM_REGS-1:0] acc_vec;
   logic [REG_W-1:0]  rd_vec   [NUM_REGS];
   cfg_t              ctrl_cfg;
   cfg_t              win_cfg;

   assign fuse_arr[SEL_CTRL] = fuse_per;
   assign fuse_arr[SEL_WIN]  = fuse_wper;
   assign unused_rsvd        = ^wr_data[REG_W-1:CODE_LSB+CODE_W];

   winwdog_unlock #(.OPEN_CYC(OPEN_CYC)) u_unlock (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (unlock_stb),
      .open_o (unlocked)
   );

   winwdog_tickin #(.LEVEL_TICK(LEVEL_TICK)) u_tickin (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_in (tick),
      .tick_o  (tick_int)
   );

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      logic hit;
      assign hit = wr_en && (wr_sel == 1'(g));

      winwdog_cfgreg #(.MAX_CODE(MAX_CODE)) u_reg (
         .clk        (clk),
         .rst_n      (rst_n),
         .fuse_code  (fuse_arr[g]),
         .wr_hit     (hit),
         .wr_ce      (wr_data[CE_BIT]),
         .wr_en_bit  (wr_data[EN_BIT]),
         .wr_code    (wr_data[CODE_LSB +: CODE_W]),
         .unlocked   (unlocked),
         .per_lock   (per_lock),
         .cfg_o      (cfg_arr[g]),
         .accepted_o (acc_vec[g])
      );

      assign rd_vec[g] = {{PAD_W{1'b0}}, cfg_arr[g].code, cfg_arr[g].en, 1'b0};
   end

   assign ctrl_cfg = cfg_arr[SEL_CTRL];
   assign win_cfg  = cfg_arr[SEL_WIN];
   assign restart  = |acc_vec;
   assign rd_data  = rd_vec[rd_sel];

   winwdog_count #(
      .BASE_SHIFT (BASE_SHIFT),
      .MAX_CODE   (MAX_CODE)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_int),
      .kick     (kick),
      .restart  (restart),
      .run      (ctrl_cfg.en),
      .win_mode (win_cfg.en),
      .per_code (ctrl_cfg.code),
      .win_code (win_cfg.code),
      .req_o    (sys_rst_req),
      .early_o  (rst_early)
   );

endmodule

// File: rtl/winwdog_chk.sv
module winwdog_chk
   import winwdog_pkg::*;
#(
   parameter int unsigned MAX_CODE = 10
) (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_en,
   input logic [7:0] wr_data,
   input logic       per_lock,
   input logic       unlock_stb,
   input logic       unlocked,
   input cfg_t       ctrl_cfg,
   input cfg_t       win_cfg,
   input logic [7:0] rd_data,
   input logic       sys_rst_req,
   input logic       rst_early
);

   assert_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[7:6] == 2'b00) && (rd_data[0] == 1'b0));

   assert_ce_required_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[0]) |=> ($stable(ctrl_cfg) && $stable(win_cfg)));

   assert_unlock_opens_R4: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_stb |=> unlocked);

   assert_closed_write_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !unlocked) |=> ($stable(ctrl_cfg) && $stable(win_cfg)));

   assert_reserved_rejected_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !per_lock && (wr_data[5:2] > 4'(MAX_CODE)))
      |=> ($stable(ctrl_cfg) && $stable(win_cfg)));

   assert_lock_freezes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      per_lock |=> ($stable(ctrl_cfg.code) && $stable(win_cfg.code)));

   assert_early_in_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rst_early |-> (sys_rst_req && $past(win_cfg.en)));

   assert_quiet_when_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(ctrl_cfg.en) |-> !sys_rst_req);

endmodule

bind winwdog_top winwdog_chk #(.MAX_CODE(MAX_CODE)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .per_lock    (per_lock),
   .unlock_stb  (unlock_stb),
   .unlocked    (unlocked),
   .ctrl_cfg    (ctrl_cfg),
   .win_cfg     (win_cfg),
   .rd_data     (rd_data),
   .sys_rst_req (sys_rst_req),
   .rst_early   (rst_early)
);

// File: tb/winwdog_top_test.sv
module winwdog_top_test;

   localparam logic [3:0] FPER  = 4'd2;
   localparam logic [3:0] FWPER = 4'd1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0, kick = 1'b0, unlock_stb = 1'b0, per_lock = 1'b0;
   logic       wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       sys_rst_req, rst_early;

   int    tests = 0, fails = 0, req_seen = 0, early_seen = 0;
   bit    done = 1'b0;
   string phase = "R1";

   always #10 clk = ~clk;

   winwdog_top uut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .kick(kick), .unlock_stb(unlock_stb),
      .per_lock(per_lock), .fuse_per(FPER), .fuse_wper(FWPER), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .sys_rst_req(sys_rst_req), .rst_early(rst_early)
   );

   task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
      end
   endtask

   // behavioural reference model
   int m_unl, m_per, m_wper, m_cnt;
   bit m_en, m_wen, m_req, m_early;

   function automatic int ticks_of(input int c);
      return 8 * (1 << c);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_unl = 0; m_per = FPER; m_wper = FWPER; m_en = 0; m_wen = 0;
         m_cnt = 0; m_req = 0; m_early = 0;
      end else begin
         bit acc;
         int code, lim;
         code = wr_data[5:2];
         acc  = wr_en && (m_unl > 0) && wr_data[0] && (per_lock || code <= 10);
         m_req = 0; m_early = 0;
         if (!m_en || acc) m_cnt = 0;
         else if (kick) begin
            if (m_wen && m_cnt < ticks_of(m_wper)) begin m_req = 1; m_early = 1; end
            m_cnt = 0;
         end else if (tick) begin
            lim = ticks_of(m_per) + (m_wen ? ticks_of(m_wper) : 0);
            if (m_cnt == lim - 1) begin m_req = 1; m_cnt = 0; end
            else m_cnt++;
         end
         if (acc) begin
            if (!wr_sel) begin m_en = wr_data[1]; if (!per_lock) m_per = code; end
            else begin m_wen = wr_data[1]; if (!per_lock) m_wper = code; end
         end
         if (unlock_stb) m_unl = 4;
         else if (m_unl > 0) m_unl--;
      end
   end

   // per-cycle comparison, 5 ns after the rising edge
   always @(posedge clk) begin
      logic [7:0] exp_rd;
      #5;
      if (rst_n && !done) begin
         exp_rd = rd_sel ? {2'b00, 4'(m_wper), m_wen, 1'b0} : {2'b00, 4'(m_per), m_en, 1'b0};
         chk(sys_rst_req === m_req, phase, "model sys_rst_req", int'(sys_rst_req), int'(m_req));
         chk(rst_early === m_early, phase, "model rst_early", int'(rst_early), int'(m_early));
         chk(rd_data === exp_rd, phase, "model rd_data", int'(rd_data), int'(exp_rd));
         if (sys_rst_req) req_seen++;
         if (rst_early) early_seen++;
      end
   end

   task automatic wait_neg(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_write(input bit sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic do_unlock();
      unlock_stb = 1'b1;
      @(negedge clk);
      unlock_stb = 1'b0;
   endtask

   task automatic unlocked_write(input bit sel, input logic [7:0] d);
      do_unlock();
      do_write(sel, d);
      @(negedge clk);
   endtask

   task automatic read_chk(input bit sel, input logic [7:0] exp, input string r);
      rd_sel = sel;
      #2;
      chk(rd_data === exp, r, "readback", int'(rd_data), int'(exp));
   endtask

   task automatic tick_once();
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) tick_once();
   endtask

   task automatic kick_once();
      kick = 1'b1;
      @(negedge clk);
      kick = 1'b0;
      @(negedge clk);
   endtask

   // n-1 ticks give no request, tick n gives exactly one
   task automatic expect_timeout(input int n, input string r);
      int base;
      base = req_seen;
      ticks(n - 1);
      chk(req_seen == base, r, "no request before timeout", req_seen - base, 0);
      tick_once();
      chk(req_seen == base + 1, r, "request on final tick", req_seen - base, 1);
   endtask

   task automatic finish_up();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   initial begin
      int b, e;
      wait_neg(5);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 fuse defaults and quiet outputs
      phase = "R1";
      read_chk(1'b0, {2'b00, FPER, 2'b00}, "R1");
      read_chk(1'b1, {2'b00, FWPER, 2'b00}, "R1");
      chk(sys_rst_req === 1'b0 && rst_early === 1'b0, "R1", "outputs after reset", int'(sys_rst_req), 0);

      // R4 write without unlock discarded
      phase = "R4";
      do_write(1'b0, 8'h03);
      read_chk(1'b0, {2'b00, FPER, 2'b00}, "R4");

      // R3 write without change-enable
      phase = "R3";
      do_unlock();
      do_write(1'b0, 8'h02);
      read_chk(1'b0, {2'b00, FPER, 2'b00}, "R3");
      wait_neg(5);

      // R4 fifth edge after strobe is too late
      phase = "R4";
      do_unlock();
      wait_neg(4);
      do_write(1'b0, 8'h03);
      read_chk(1'b0, {2'b00, FPER, 2'b00}, "R4");

      // R4 fourth edge accepted; R2 reserved and CE bits read zero
      do_unlock();
      wait_neg(3);
      do_write(1'b0, 8'hC3);
      read_chk(1'b0, 8'h02, "R2");
      wait_neg(5);

      // R8 normal timeout, code 0 = 8 ticks, then restart
      phase = "R8";
      e = early_seen;
      expect_timeout(8, "R8");
      expect_timeout(8, "R8");
      chk(early_seen == e, "R8", "no early flag on timeout", early_seen - e, 0);

      // R9 kick restarts count
      phase = "R9";
      b = req_seen;
      ticks(5);
      kick_once();
      ticks(7);
      chk(req_seen == b, "R9", "kick restarted count", req_seen - b, 0);
      tick_once();
      chk(req_seen == b + 1, "R9", "timeout after kick", req_seen - b, 1);

      // R14 kick and tick on the same edge
      phase = "R14";
      b = req_seen;
      ticks(7);
      tick = 1'b1; kick = 1'b1;
      @(negedge clk);
      tick = 1'b0; kick = 1'b0;
      @(negedge clk);
      ticks(7);
      chk(req_seen == b, "R14", "kick wins over tick", req_seen - b, 0);
      tick_once();
      chk(req_seen == b + 1, "R14", "timeout after combined edge", req_seen - b, 1);

      // R5 reserved code rejected
      phase = "R5";
      unlocked_write(1'b0, 8'h2F);
      read_chk(1'b0, 8'h02, "R5");

      // R7 code 6 = 512 ticks, code 10 = 8192 ticks
      phase = "R7";
      unlocked_write(1'b0, 8'h1B);
      read_chk(1'b0, 8'h1A, "R7");
      expect_timeout(512, "R7");
      unlocked_write(1'b0, 8'h2B);
      expect_timeout(8192, "R7");

      // window mode: control code 0 (8), window code 1 (16)
      phase = "R10";
      unlocked_write(1'b0, 8'h03);
      unlocked_write(1'b1, 8'h07);
      read_chk(1'b1, 8'h06, "R10");
      b = req_seen; e = early_seen;
      ticks(3);
      kick_once();
      chk(req_seen == b + 1, "R10", "request on early kick", req_seen - b, 1);
      chk(early_seen == e + 1, "R10", "early flag on early kick", early_seen - e, 1);

      phase = "R9";
      b = req_seen;
      ticks(16);
      kick_once();
      chk(req_seen == b, "R9", "open window kick silent", req_seen - b, 0);

      phase = "R11";
      e = early_seen;
      expect_timeout(24, "R11");
      chk(early_seen == e, "R11", "window timeout not early", early_seen - e, 0);

      // R12 window code ignored with window mode off
      phase = "R12";
      unlocked_write(1'b1, 8'h15);
      read_chk(1'b1, 8'h14, "R12");
      b = req_seen; e = early_seen;
      ticks(2);
      kick_once();
      chk(req_seen == b && early_seen == e, "R12", "kick not early in normal mode", req_seen - b, 0);
      expect_timeout(8, "R12");

      // R6 lock keeps period, enable still writable
      phase = "R6";
      per_lock = 1'b1;
      unlocked_write(1'b0, 8'h0D);
      read_chk(1'b0, 8'h00, "R6");
      unlocked_write(1'b0, 8'hFF);
      read_chk(1'b0, 8'h02, "R6");

      // R13 disabled: no requests
      phase = "R13";
      unlocked_write(1'b0, 8'h01);
      read_chk(1'b0, 8'h00, "R13");
      b = req_seen;
      ticks(20);
      chk(req_seen == b, "R13", "no request while disabled", req_seen - b, 0);
      per_lock = 1'b0;

      wait_neg(3);
      finish_up();
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_up();
      end
   end

endmodule